// File: doc/BRIEF.md
# Four-Phase Register Add Executor

This block is a small non-pipelined execution core. Every instruction takes exactly four clock phases: the instruction pointer goes out to a synchronous instruction memory, the returned word is captured, the register operands are read and latched, and then a combinational adder produces the result. The result is written back to the destination register on the closing edge of the fourth phase. The core then returns to its idle phase and can start the next instruction.

Instructions are 32-bit words split into four byte fields. The register file holds 256 words of 32 bits. The only arithmetic operation is an unsigned add that also reports a carry flag and a two's-complement overflow flag. Every other operator value moves through the same four phases without any effect. A debug side port reads any register at any time, and it can seed a register while the core is idle and held. A one-cycle retire strobe marks each completed instruction.

Top module: `mc_core`

## Requirements
- R1: After reset the core is idle, `imem_addr` is 0, `retire`, `carry_flag` and `ovf_flag` are 0, and every register reads 0 on the debug port.
- R2: Instruction fields are operator in bits [31:24], first source index in [23:16], second source index in [15:8] and destination index in [7:0]. Only the destination is written; both sources keep their values.
- R3: Operator value 0xD7 writes (first source + second source) modulo 2^32 to the destination, so that 0xD70001FF places R0+R1 into R255.
- R4: On an add, `carry_flag` becomes the carry out of bit 31. `ovf_flag` becomes 1 exactly when both operands have equal bit 31 and the sum's bit 31 differs from it. Example: 0x50F58800+0x50F58800 gives 0xA1EB1000 with carry 0 and overflow 1.
- R5: Any operator value other than 0xD7 writes no register and leaves both flags unchanged.
- R6: An instruction started from idle on edge 1 raises `retire` for exactly one cycle after edge 4, with the core idle. With `run` held high, instructions retire every four cycles.
- R7: `imem_addr` is the instruction pointer. It starts at 0 and increases by one on each edge that starts an instruction. Memory data returned one cycle after the address is the instruction executed.
- R8: When a source index equals the destination index, the old register value is the operand, so R5=R5+R5 doubles R5.
- R9: While idle with `run` low, the core stays idle and `imem_addr` holds. `dbg_we` writes `dbg_wdata` to register `dbg_sel` only in that condition and is ignored otherwise. `dbg_rdata` shows register `dbg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start an instruction when idle |
| imem_addr | output | 16 | Instruction pointer to the memory (word address) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| dbg_sel | input | 8 | Register index for debug read and write |
| dbg_we | input | 1 | Debug register write strobe |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Contents of register `dbg_sel` |
| retire | output | 1 | One-cycle strobe when write-back completes |
| carry_flag | output | 1 | Carry out of the last add |
| ovf_flag | output | 1 | Signed overflow of the last add |

## Verification
The assertions assume that `run` and the debug inputs change only between edges. They also assume that the instruction memory answers with one cycle of latency for whatever address the core presented. The bench's memory model returns the word at the previous cycle's address, and the bench drives every input on the falling edge. The bench seeds operands only while the core is idle and held. The single exception is a deliberate debug write during a busy phase, which checks that such a write is dropped.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int FIELD_W = 8;
    localparam int INSTR_W = 4 * FIELD_W;
    localparam logic [FIELD_W-1:0] OPC_ADD = 8'hD7;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_FETCHED  = 2'd1,
        ST_DECODED  = 2'd2,
        ST_EXECUTED = 2'd3
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] opc;
        logic [FIELD_W-1:0] src1;
        logic [FIELD_W-1:0] src2;
        logic [FIELD_W-1:0] dst;
    } instr_t;
endpackage

// File: rtl/mc_seq.sv
module mc_seq
    import mc_pkg::*;
#(
    parameter int IP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output phase_e          phase,
    output logic [IP_W-1:0] ip
);
    typedef struct packed {
        phase_e          phase;
        logic [IP_W-1:0] ip;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.phase)
            ST_READY: begin
                if (run) begin
                    seq_d.phase = ST_FETCHED;
                    seq_d.ip    = seq_q.ip + 1'b1;
                end
            end
            ST_FETCHED:  seq_d.phase = ST_DECODED;
            ST_DECODED:  seq_d.phase = ST_EXECUTED;
            default:     seq_d.phase = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= ST_READY;
            seq_q.ip    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;
    assign ip    = seq_q.ip;

    // R6: a busy phase never repeats
    a_r6_phase_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_READY) |=> (phase != $past(phase)));
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd2,
    input  logic [AW-1:0] ra3,
    output logic [DW-1:0] rd3
);
    localparam int NREGS = 1 << AW;

    logic [DW-1:0] mem_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rd1 = mem_q[ra1];
    assign rd2 = mem_q[ra2];
    assign rd3 = mem_q[ra3];
endmodule

// File: rtl/mc_add_unit.sv
module mc_add_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          ovf
);
    logic [DW:0] wide;

    always_comb begin
        wide  = {1'b0, a} + {1'b0, b};
        sum   = wide[DW-1:0];
        carry = wide[DW];
        ovf   = (a[DW-1] == b[DW-1]) && (wide[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    output logic [IP_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic [FIELD_W-1:0] dbg_sel,
    input  logic               dbg_we,
    input  logic [DW-1:0]      dbg_wdata,
    output logic [DW-1:0]      dbg_rdata,
    output logic               retire,
    output logic               carry_flag,
    output logic               ovf_flag
);
    localparam int RA_W = FIELD_W;

    typedef struct packed {
        instr_t             ir;
        logic [FIELD_W-1:0] opc;
        logic [RA_W-1:0]    dst;
        logic [DW-1:0]      opa;
        logic [DW-1:0]      opb;
        logic               carry;
        logic               ovf;
        logic               retire;
    } core_t;

    core_t core_d, core_q;

    phase_e          phase;
    logic [DW-1:0]   rd1, rd2, sum;
    logic            add_carry, add_ovf;
    logic            exe_wr, dbg_wr, rf_we;
    logic [RA_W-1:0] rf_waddr;
    logic [DW-1:0]   rf_wdata;

    mc_seq #(.IP_W(IP_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .phase (phase),
        .ip    (imem_addr)
    );

    mc_regfile #(.DW(DW), .AW(RA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra1   (core_q.ir.src1),
        .rd1   (rd1),
        .ra2   (core_q.ir.src2),
        .rd2   (rd2),
        .ra3   (dbg_sel),
        .rd3   (dbg_rdata)
    );

    mc_add_unit #(.DW(DW)) u_add (
        .a     (core_q.opa),
        .b     (core_q.opb),
        .sum   (sum),
        .carry (add_carry),
        .ovf   (add_ovf)
    );

    always_comb begin
        core_d        = core_q;
        core_d.retire = 1'b0;
        case (phase)
            ST_FETCHED: core_d.ir = imem_rdata;
            ST_DECODED: begin
                core_d.opc = core_q.ir.opc;
                core_d.dst = core_q.ir.dst;
                core_d.opa = rd1;
                core_d.opb = rd2;
            end
            ST_EXECUTED: begin
                core_d.retire = 1'b1;
                if (core_q.opc == OPC_ADD) begin
                    core_d.carry = add_carry;
                    core_d.ovf   = add_ovf;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        exe_wr   = (phase == ST_EXECUTED) && (core_q.opc == OPC_ADD);
        dbg_wr   = (phase == ST_READY) && !run && dbg_we;
        rf_we    = exe_wr || dbg_wr;
        rf_waddr = exe_wr ? core_q.dst : dbg_sel;
        rf_wdata = exe_wr ? sum : dbg_wdata;
    end

    assign retire     = core_q.retire;
    assign carry_flag = core_q.carry;
    assign ovf_flag   = core_q.ovf;

    // R6: the retire strobe falls in the idle phase and lasts one cycle
    a_r6_retire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (phase == ST_READY));
    a_r6_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R7: starting an instruction advances the pointer by one word
    a_r7_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_READY) && run) |=> (imem_addr == IP_W'($past(imem_addr) + 1'b1)));

    // R9: a held idle core stays put
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_READY) && !run) |=> ((phase == ST_READY) && $stable(imem_addr)));

    // R5: flags move only on an executed add
    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exe_wr |=> $stable({carry_flag, ovf_flag}));

    // R4: carry out equals wrap of the sum below an operand
    a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
        exe_wr |=> (carry_flag == ($past(sum) < $past(core_q.opa))));
endmodule

// File: tb/sim_mc_core.sv
`timescale 1ns/1ps
module sim_mc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [7:0]  dbg_sel = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        retire, carry_flag, ovf_flag;

    logic [31:0] imem [64];
    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_ip = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) imem_rdata <= imem[imem_addr[5:0]];

    mc_core u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .dbg_sel(dbg_sel), .dbg_we(dbg_we),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .retire(retire),
        .carry_flag(carry_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic seed(input logic [7:0] idx, input logic [31:0] val);
        @(negedge clk);
        dbg_we = 1'b1; dbg_sel = idx; dbg_wdata = val;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] idx, output logic [31:0] val);
        dbg_sel = idx;
        #0.5;
        val = dbg_rdata;
    endtask

    task automatic run_one(input logic [31:0] iw);
        int cnt;
        imem[exp_ip[5:0]] = iw;
        @(negedge clk); run = 1'b1;
        @(negedge clk); run = 1'b0;
        exp_ip = exp_ip + 1'b1;
        chk("R7 pointer after start", 32'(imem_addr), 32'(exp_ip));
        cnt = 1;
        while (!retire && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk("R6 retire after four edges", 32'(cnt), 32'd4);
    endtask

    function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        logic o;
        w = {1'b0, a} + {1'b0, b};
        o = (a[31] == b[31]) && (w[31] != a[31]);
        return {w[32], o, w[31:0]};
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] pat [7];
        logic [33:0] r;
        for (int i = 0; i < 64; i++) imem[i] = 32'h0;
        pat[0] = 32'h0;        pat[1] = 32'h1;        pat[2] = 32'h7FFFFFFF;
        pat[3] = 32'h80000000; pat[4] = 32'hFFFFFFFF; pat[5] = 32'h50F58800;
        pat[6] = 32'h12345678;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 imem_addr", 32'(imem_addr), 32'h0);
        chk("R1 retire", 32'(retire), 32'h0);
        chk("R1 carry", 32'(carry_flag), 32'h0);
        chk("R1 ovf", 32'(ovf_flag), 32'h0);
        for (int i = 0; i < 256; i++) begin
            peek(8'(i), v);
            chk("R1 register zero", v, 32'h0);
        end

        // R3/R4 worked example: R255 = R0 + R1
        seed(8'h00, 32'h50F58800);
        seed(8'h01, 32'h50F58800);
        run_one(32'hD70001FF);
        peek(8'hFF, v);
        chk("R3 example sum", v, 32'hA1EB1000);
        chk("R4 example carry", 32'(carry_flag), 32'h0);
        chk("R4 example ovf", 32'(ovf_flag), 32'h1);

        // R2/R3/R4 sweep over operand patterns and field positions
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                logic [7:0] s1, s2, d;
                s1 = 8'(i * 3 + 1);
                s2 = 8'(j * 5 + 100);
                d  = 8'(200 + i * 7 + j);
                seed(s1, pat[i]);
                seed(s2, pat[j]);
                run_one({8'hD7, s1, s2, d});
                r = ref_add(pat[i], pat[j]);
                peek(d, v);
                chk("R3 sum", v, r[31:0]);
                chk("R4 carry", 32'(carry_flag), 32'(r[33]));
                chk("R4 ovf", 32'(ovf_flag), 32'(r[32]));
                peek(s1, v);
                chk("R2 src1 kept", v, pat[i]);
                peek(s2, v);
                chk("R2 src2 kept", v, pat[j]);
            end
        end

        // R8 destination equals source
        seed(8'd5, 32'h80000001);
        run_one(32'hD7050505);
        peek(8'd5, v);
        chk("R8 doubled", v, 32'h00000002);
        chk("R8 carry", 32'(carry_flag), 32'h1);
        chk("R8 ovf", 32'(ovf_flag), 32'h1);

        // R5 every other operator: no write, flags hold at 1/1
        seed(8'd10, 32'h00000003);
        seed(8'd20, 32'h00000004);
        for (int op = 0; op < 256; op++) begin
            if (op != 8'hD7) begin
                seed(8'd30, 32'hC0DE0000 | 32'(op));
                run_one({8'(op), 8'd10, 8'd20, 8'd30});
                peek(8'd30, v);
                chk("R5 no write", v, 32'hC0DE0000 | 32'(op));
                chk("R5 carry held", 32'(carry_flag), 32'h1);
                chk("R5 ovf held", 32'(ovf_flag), 32'h1);
            end
        end

        // R9 held idle core
        repeat (10) begin
            @(negedge clk);
            chk("R9 pointer held", 32'(imem_addr), 32'(exp_ip));
            chk("R9 no retire", 32'(retire), 32'h0);
        end

        // R9 debug write during a busy phase is dropped
        seed(8'd40, 32'h11111111);
        imem[exp_ip[5:0]] = 32'h00000000;
        @(negedge clk); run = 1'b1;
        @(negedge clk); run = 1'b0;
        dbg_we = 1'b1; dbg_sel = 8'd40; dbg_wdata = 32'hDEADBEEF;
        @(negedge clk); dbg_we = 1'b0;
        exp_ip = exp_ip + 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 retire", 32'(retire), 32'h1);
        peek(8'd40, v);
        chk("R9 busy write ignored", v, 32'h11111111);

        // R6/R7 back-to-back with data dependence
        seed(8'h3D, 32'd5);
        seed(8'h3E, 32'd7);
        imem[exp_ip[5:0]]        = 32'hD73D3E3C;
        imem[6'(exp_ip[5:0] + 1)] = 32'hD73C3C3F;
        imem[6'(exp_ip[5:0] + 2)] = 32'hD73F3D40;
        @(negedge clk); run = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk("R6 back-to-back retire", 32'(retire), (k % 4 == 0) ? 32'h1 : 32'h0);
            if (k == 12) run = 1'b0;
        end
        exp_ip = exp_ip + 16'd3;
        chk("R7 pointer after three", 32'(imem_addr), 32'(exp_ip));
        peek(8'h3C, v); chk("R6 first result", v, 32'd12);
        peek(8'h3F, v); chk("R6 second result", v, 32'd24);
        peek(8'h40, v); chk("R6 third result", v, 32'd29);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule